// File: doc/BRIEF.md
# Pixel format repacker

The repacker sits between a 32-bit transmit word queue and a byte-serial display transmitter. It takes packed pixel words, pulls pixels out of them according to one of eight memory layouts, and re-encodes each pixel as a 16-bit 5-6-5 value (two bytes) or a 24-bit 8-8-8 value (three bytes). Each byte leaves on a valid/ready handshake. Three-byte layouts pack pixels back to back, so one pixel can start in one word and end in the next. A short byte window inside the block joins those pieces.

A job starts with a one-cycle `start` pulse. The pulse captures the input layout, the output depth and the pixel count. The block fetches only the words that the remaining pixels need. Once the last pixel has been taken, any bytes left in the final word are dropped. `done` rises after the last output byte has been accepted.

The control machine has four states:
- IDLE: the state after reset.
- RUN: words are fetched and pixels are converted.
- FLUSH: the last pixel has been handed on and its bytes are still draining.
- DONE: the job is finished.

The transitions are:
- IDLE or DONE goes to RUN on `start` with a non-zero count.
- IDLE or DONE goes to DONE on `start` with a zero count.
- RUN goes to FLUSH when the last pixel is handed to the serializer.
- FLUSH goes to DONE when the serializer holds no more bytes.

Top module: `pix_repack`

## Requirements
- R1: After reset, `busy`, `done`, `ob_valid` and `wr_ready` are all low. `busy` and `done` are never high together.
- R2: Byte k of a word (k = 0..3) is `wr_data[8k+7:8k]`. Byte 0 comes first in memory order. The four-byte layouts are:
  - Layout 0: red, green, blue, then a pad byte.
  - Layout 1: blue, green, red, then a pad byte.
  - Layout 2: a pad byte, then red, green, blue.
  - Layout 3: a pad byte, then blue, green, red.
- R3: Layout 4 (red, green, blue) and layout 5 (blue, green, red) use three bytes per pixel with no padding. A pixel may span two consecutive words.
- R4: Layouts 6 and 7 carry two 16-bit pixels per word, and the lower halfword is the first pixel. Within a halfword, memory byte 0 is bits 7:0 and memory byte 1 is bits 15:8.
  - Layout 6 holds blue in bits 15:11, green in bits 10:5 and red in bits 4:0.
  - Layout 7 holds red in bits 15:11, green in bits 10:5 and blue in bits 4:0.
- R5: With `out_fmt` = 0, each pixel leaves as two bytes: first `{R[7:3],G[7:5]}`, then `{G[4:2],B[7:3]}`. Eight-bit channels are truncated to their top bits. 5-6-5 input is passed through unchanged.
- R6: With `out_fmt` = 1, each pixel leaves as three bytes in the order red, green, blue. A 5-bit field v is widened to `{v, v[4:2]}` and a 6-bit field g to `{g, g[5:4]}`.
- R7: While `ob_valid` is high and `ob_ready` is low, `ob_valid` stays high and `ob_data` stays unchanged on the next cycle.
- R8: A job of N pixels at b bytes per pixel consumes exactly ceil(N·b/4) words. Bytes left in the last word are never output. After the final byte, `done` rises. While `done` is high, `ob_valid` and `wr_ready` are low.
- R9: A `start` with `pix_count` = 0 moves the block to DONE on the next cycle. No word is consumed and no byte is output.
- R10: Layout, depth and count are sampled only on an accepted `start`. A `start` is accepted only in IDLE or DONE. A `start` while `busy` is high is ignored, and input changes after an accepted `start` have no effect on the running job.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | One-cycle job start |
| in_fmt | input | 3 | Input memory layout 0..7 |
| out_fmt | input | 1 | 0 = 5-6-5 two bytes, 1 = 8-8-8 three bytes |
| pix_count | input | CNT_W | Pixels in the job |
| wr_data | input | 32 | Packed pixel word |
| wr_valid | input | 1 | Word offered |
| wr_ready | output | 1 | Word accepted this cycle when high with `wr_valid` |
| ob_data | output | 8 | Output byte |
| ob_valid | output | 1 | Output byte offered |
| ob_ready | input | 1 | Output byte taken this cycle when high with `ob_valid` |
| busy | output | 1 | Job in RUN or FLUSH |
| done | output | 1 | Job finished (DONE state) |

## Verification
A byte window that miscounts its fill level is the likeliest internal fault. It shifts every later pixel of the job: the first wrong byte appears within one pixel, and the number of words consumed moves away from ceil(N·b/4). A wrong remaining-pixel count shows at the ports in two ways: `done` comes too early or never comes, or an extra word is drawn before `done` rises. A serializer that reloads too soon breaks the hold rule on `ob_data` in the very next cycle of a stall. The bench therefore compares every output byte, and each job's word count, against a model built from the layout rules, under gapped input and random output stalls.

// File: rtl/pixrp_pkg.sv
`timescale 1ns/1ps
package pixrp_pkg;

    typedef enum logic [2:0] {
        IF_RGBX  = 3'd0,
        IF_BGRX  = 3'd1,
        IF_XRGB  = 3'd2,
        IF_XBGR  = 3'd3,
        IF_RGB24 = 3'd4,
        IF_BGR24 = 3'd5,
        IF_BGR16 = 3'd6,
        IF_RGB16 = 3'd7
    } pix_in_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_FLUSH = 2'd2,
        ST_DONE  = 2'd3
    } rp_state_e;

    typedef struct packed {
        logic [7:0] r;
        logic [7:0] g;
        logic [7:0] b;
    } rgb_t;

    // Bytes one pixel occupies in memory for a given layout.
    function automatic logic [2:0] in_bytes(pix_in_e f);
        logic [2:0] n;
        unique case (f)
            IF_RGBX, IF_BGRX, IF_XRGB, IF_XBGR: n = 3'd4;
            IF_RGB24, IF_BGR24:                 n = 3'd3;
            default:                            n = 3'd2;
        endcase
        return n;
    endfunction

endpackage

// File: rtl/pixrp_unpack.sv
`timescale 1ns/1ps
module pixrp_unpack
    import pixrp_pkg::*;
#(
    parameter int WANT_W = 27
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              en,
    input  pix_in_e           fmt,
    input  logic [WANT_W-1:0] want,
    input  logic [31:0]       wr_data,
    input  logic              wr_valid,
    output logic              wr_ready,
    output logic [31:0]       pix_raw,
    output logic              pix_valid,
    input  logic              pix_ready
);

    localparam int WIN_BYTES = 8;
    localparam int WORD_BYTES = 4;

    logic [7:0] win_q [WIN_BYTES];
    logic [7:0] win_n [WIN_BYTES];
    logic [3:0] fill_q;
    logic [3:0] fill_n;
    logic [3:0] bpp;
    logic [3:0] take;
    logic [3:0] fill_sh;
    logic [3:0] src;
    logic [3:0] pos;
    logic       accept;

    assign bpp       = {1'b0, in_bytes(fmt)};
    assign pix_valid = en && (fill_q >= bpp) && (want != '0);
    assign wr_ready  = en && (fill_q <= 4'd4)
                       && ({{(WANT_W-4){1'b0}}, fill_q} < want);
    assign accept    = wr_valid && wr_ready;
    assign take      = (pix_valid && pix_ready) ? bpp : 4'd0;
    assign fill_sh   = fill_q - take;
    assign fill_n    = fill_sh + (accept ? 4'd4 : 4'd0);
    assign pix_raw   = {win_q[3], win_q[2], win_q[1], win_q[0]};

    always_comb begin
        src = '0;
        pos = '0;
        for (int j = 0; j < WIN_BYTES; j++) begin
            win_n[j] = 8'h00;
            src = 4'(j) + take;
            if (!src[3]) win_n[j] = win_q[src[2:0]];
            for (int i = 0; i < WORD_BYTES; i++) begin
                pos = fill_sh + 4'(i);
                if (accept && pos == 4'(j)) win_n[j] = wr_data[8*i +: 8];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fill_q <= '0;
            for (int j = 0; j < WIN_BYTES; j++) win_q[j] <= 8'h00;
        end else if (clr) begin
            fill_q <= '0;
        end else begin
            fill_q <= fill_n;
            for (int j = 0; j < WIN_BYTES; j++) win_q[j] <= win_n[j];
        end
    end

endmodule

// File: rtl/pixrp_decode.sv
`timescale 1ns/1ps
module pixrp_decode
    import pixrp_pkg::*;
(
    input  pix_in_e     fmt,
    input  logic [31:0] raw,
    output rgb_t        px
);

    logic [15:0] half;
    logic [4:0]  r5;
    logic [5:0]  g6;
    logic [4:0]  b5;

    assign half = raw[15:0];

    always_comb begin
        r5 = half[4:0];
        g6 = half[10:5];
        b5 = half[15:11];
        unique case (fmt)
            IF_RGBX, IF_RGB24: px = '{r: raw[7:0],   g: raw[15:8],  b: raw[23:16]};
            IF_BGRX, IF_BGR24: px = '{r: raw[23:16], g: raw[15:8],  b: raw[7:0]};
            IF_XRGB:           px = '{r: raw[15:8],  g: raw[23:16], b: raw[31:24]};
            IF_XBGR:           px = '{r: raw[31:24], g: raw[23:16], b: raw[15:8]};
            IF_BGR16, IF_RGB16: begin
                if (fmt == IF_RGB16) begin
                    r5 = half[15:11];
                    b5 = half[4:0];
                end
                px = '{r: {r5, r5[4:2]}, g: {g6, g6[5:4]}, b: {b5, b5[4:2]}};
            end
        endcase
    end

endmodule

// File: rtl/pixrp_serial.sv
`timescale 1ns/1ps
module pixrp_serial
    import pixrp_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       wide,
    input  rgb_t       px,
    input  logic       px_valid,
    output logic       px_ready,
    output logic [7:0] ob_data,
    output logic       ob_valid,
    input  logic       ob_ready,
    output logic       empty
);

    logic [23:0] sh_q;
    logic [1:0]  left_q;
    logic        fire;
    logic        load;

    assign ob_valid = (left_q != 2'd0);
    assign ob_data  = sh_q[23:16];
    assign empty    = (left_q == 2'd0);
    assign fire     = ob_valid && ob_ready;
    assign px_ready = (left_q == 2'd0) || (left_q == 2'd1 && ob_ready);
    assign load     = px_valid && px_ready;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q   <= '0;
            left_q <= '0;
        end else if (load) begin
            if (wide) begin
                sh_q   <= {px.r, px.g, px.b};
                left_q <= 2'd3;
            end else begin
                sh_q   <= {px.r[7:3], px.g[7:5], px.g[4:2], px.b[7:3], 8'h00};
                left_q <= 2'd2;
            end
        end else if (fire) begin
            sh_q   <= {sh_q[15:0], 8'h00};
            left_q <= left_q - 2'd1;
        end
    end

endmodule

// File: rtl/pix_repack.sv
`timescale 1ns/1ps
module pix_repack
    import pixrp_pkg::*;
#(
    parameter int CNT_W = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [2:0]       in_fmt,
    input  logic             out_fmt,
    input  logic [CNT_W-1:0] pix_count,
    input  logic [31:0]      wr_data,
    input  logic             wr_valid,
    output logic             wr_ready,
    output logic [7:0]       ob_data,
    output logic             ob_valid,
    input  logic             ob_ready,
    output logic             busy,
    output logic             done
);

    localparam int WANT_W = CNT_W + 3;

    rp_state_e         state_q;
    rp_state_e         state_n;
    pix_in_e           fmt_q;
    logic              wide_q;
    logic [CNT_W-1:0]  rem_q;
    logic [WANT_W-1:0] want;
    logic              start_ok;
    logic              run_en;
    logic [31:0]       pix_raw;
    logic              pix_valid;
    logic              pix_ready;
    logic              pix_fire;
    logic              ser_empty;
    rgb_t              px;

    assign start_ok = start && (state_q == ST_IDLE || state_q == ST_DONE);
    assign pix_fire = pix_valid && pix_ready;
    assign want     = WANT_W'(rem_q) * WANT_W'(in_bytes(fmt_q));

    // Next-state logic
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_IDLE, ST_DONE:
                if (start_ok) state_n = (pix_count == '0) ? ST_DONE : ST_RUN;
            ST_RUN:
                if (pix_fire && rem_q == CNT_W'(1)) state_n = ST_FLUSH;
            ST_FLUSH:
                if (ser_empty) state_n = ST_DONE;
        endcase
    end

    // State register and job context
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            fmt_q   <= IF_RGBX;
            wide_q  <= 1'b0;
            rem_q   <= '0;
        end else begin
            state_q <= state_n;
            if (start_ok) begin
                fmt_q  <= pix_in_e'(in_fmt);
                wide_q <= out_fmt;
                rem_q  <= pix_count;
            end else if (pix_fire) begin
                rem_q <= rem_q - CNT_W'(1);
            end
        end
    end

    // State outputs
    always_comb begin
        busy   = 1'b0;
        done   = 1'b0;
        run_en = 1'b0;
        unique case (state_q)
            ST_IDLE:  ;
            ST_RUN:   begin busy = 1'b1; run_en = 1'b1; end
            ST_FLUSH: busy = 1'b1;
            ST_DONE:  done = 1'b1;
        endcase
    end

    pixrp_unpack #(.WANT_W(WANT_W)) u_unpack (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (start_ok),
        .en        (run_en),
        .fmt       (fmt_q),
        .want      (want),
        .wr_data   (wr_data),
        .wr_valid  (wr_valid),
        .wr_ready  (wr_ready),
        .pix_raw   (pix_raw),
        .pix_valid (pix_valid),
        .pix_ready (pix_ready)
    );

    pixrp_decode u_decode (
        .fmt (fmt_q),
        .raw (pix_raw),
        .px  (px)
    );

    pixrp_serial u_serial (
        .clk      (clk),
        .rst_n    (rst_n),
        .wide     (wide_q),
        .px       (px),
        .px_valid (pix_valid),
        .px_ready (pix_ready),
        .ob_data  (ob_data),
        .ob_valid (ob_valid),
        .ob_ready (ob_ready),
        .empty    (ser_empty)
    );

endmodule

// File: rtl/pix_repack_chk.sv
`timescale 1ns/1ps
module pix_repack_chk #(
    parameter int CNT_W = 24
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start,
    input logic [CNT_W-1:0] pix_count,
    input logic             wr_ready,
    input logic [7:0]       ob_data,
    input logic             ob_valid,
    input logic             ob_ready,
    input logic             busy,
    input logic             done
);

    AST_NOT_BUSY_AND_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done)); // R1

    AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (ob_valid && !ob_ready) |=> (ob_valid && $stable(ob_data))); // R7

    AST_DONE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!ob_valid && !wr_ready)); // R8

    AST_ZERO_JOB: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && pix_count == '0) |=> done); // R9

    AST_FETCH_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ready |-> busy); // R10

endmodule

bind pix_repack pix_repack_chk #(.CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .pix_count (pix_count),
    .wr_ready  (wr_ready),
    .ob_data   (ob_data),
    .ob_valid  (ob_valid),
    .ob_ready  (ob_ready),
    .busy      (busy),
    .done      (done)
);

// File: tb/pix_repack_bench.sv
`timescale 1ns/1ps
module pix_repack_bench;

    localparam int CLK_PERIOD = 10;
    localparam int CNT_W = 24;
    localparam int NVEC = 12;

    // {layout[2:0], out_fmt, pixels[3:0], word3, word2, word1, word0}
    localparam logic [135:0] VEC [NVEC] = '{
        {3'd0, 1'b1, 4'd3, 128'h00000000_44CC1A5E_77A0B1C2_99112233},
        {3'd1, 1'b1, 4'd2, 128'h00000000_00000000_5A0F3C87_E2D4C6B8},
        {3'd2, 1'b0, 4'd3, 128'h00000000_F81CE77A_0AFF8055_3C9E6B12},
        {3'd3, 1'b1, 4'd2, 128'h00000000_00000000_13579BDF_2468ACE0},
        {3'd4, 1'b1, 4'd5, 128'hDEADBEEF_0BADF00D_C0FFEE11_8899AABB},
        {3'd5, 1'b0, 4'd4, 128'h00000000_F0E1D2C3_B4A59687_78695A4B},
        {3'd4, 1'b0, 4'd1, 128'h12345678_9ABCDEF0_0FEDCBA9_55F8A4C1},
        {3'd6, 1'b1, 4'd3, 128'h00000000_00000000_ABCD8421_F81F07E0},
        {3'd7, 1'b0, 4'd8, 128'h1357ACE0_FFFF0000_F800001F_07E0A5C3},
        {3'd7, 1'b1, 4'd5, 128'h00000000_7BEF8410_0841FFFF_F81F0000},
        {3'd6, 1'b0, 4'd1, 128'h00000000_00000000_00000000_CAFE4B3D},
        {3'd5, 1'b1, 4'd3, 128'h00000000_A1B2C3D4_E5F60718_293A4B5C}
    };

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start = 1'b0;
    logic [2:0]       in_fmt = '0;
    logic             out_fmt = 1'b0;
    logic [CNT_W-1:0] pix_count = '0;
    logic [31:0]      wr_data = '0;
    logic             wr_valid = 1'b0;
    logic             wr_ready;
    logic [7:0]       ob_data;
    logic             ob_valid;
    logic             ob_ready = 1'b0;
    logic             busy;
    logic             done;

    int n_chk = 0;
    int n_fail = 0;
    int total_cyc = 0;
    logic [15:0] lfsr = 16'hACE1;

    always #(CLK_PERIOD/2) clk = ~clk;

    pix_repack #(.CNT_W(CNT_W)) u_pix_repack (.*);

    always @(posedge clk) begin
        total_cyc++;
        if (total_cyc > 60000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: run hung, got %0d cycles expected fewer", total_cyc);
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: got %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int mem_bytes(input logic [2:0] f);
        if (f <= 3'd3) return 4;
        if (f <= 3'd5) return 3;
        return 2;
    endfunction

    // Reference model built from R2..R6.
    task automatic build_ref(input logic [2:0] f, input logic wide, input int np,
                             input logic [127:0] words, ref logic [7:0] q[$]);
        logic [7:0] mb [16];
        logic [7:0] r8, g8, b8;
        logic [4:0] r5, b5;
        logic [5:0] g6;
        logic [15:0] h;
        q.delete();
        for (int j = 0; j < 16; j++) mb[j] = words[8*j +: 8];
        for (int p = 0; p < np; p++) begin
            int base = p * mem_bytes(f) + ((f == 3'd2 || f == 3'd3) ? 1 : 0);
            r8 = 0; g8 = 0; b8 = 0; r5 = 0; g6 = 0; b5 = 0;
            if (f <= 3'd5) begin
                g8 = mb[base+1];
                if (f == 3'd0 || f == 3'd2 || f == 3'd4) begin
                    r8 = mb[base]; b8 = mb[base+2];
                end else begin
                    b8 = mb[base]; r8 = mb[base+2];
                end
                if (wide) begin
                    q.push_back(r8); q.push_back(g8); q.push_back(b8);
                end else begin
                    q.push_back({r8[7:3], g8[7:5]});
                    q.push_back({g8[4:2], b8[7:3]});
                end
            end else begin
                h = {mb[base+1], mb[base]};
                g6 = h[10:5];
                if (f == 3'd6) begin b5 = h[15:11]; r5 = h[4:0]; end
                else           begin r5 = h[15:11]; b5 = h[4:0]; end
                if (wide) begin
                    q.push_back({r5, r5[4:2]});
                    q.push_back({g6, g6[5:4]});
                    q.push_back({b5, b5[4:2]});
                end else begin
                    q.push_back({r5, g6[5:3]});
                    q.push_back({g6[2:0], b5});
                end
            end
        end
    endtask

    task automatic run_vec(input int vi, input logic poke);
        logic [2:0]   f;
        logic         wide;
        int           np;
        logic [127:0] words;
        logic [7:0]   exp_q[$];
        logic [7:0]   got_q[$];
        int           widx;
        int           cyc;
        logic         seen_done;
        string        tag;
        f     = VEC[vi][135:133];
        wide  = VEC[vi][132];
        np    = int'(VEC[vi][131:128]);
        words = VEC[vi][127:0];
        build_ref(f, wide, np, words, exp_q);
        tag = (f <= 3'd3) ? "R2" : ((f <= 3'd5) ? "R3" : "R4");

        @(negedge clk);
        start = 1'b1; in_fmt = f; out_fmt = wide; pix_count = CNT_W'(np);
        wr_valid = 1'b0; ob_ready = 1'b0;
        @(negedge clk);
        // R10: changing the job inputs after start must not matter
        start = 1'b0; in_fmt = ~f; out_fmt = ~wide; pix_count = CNT_W'(7);
        widx = 0; cyc = 0; seen_done = 1'b0;
        while (!seen_done && cyc < 400) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            wr_valid = (widx < 4) && ((vi % 2 == 0) || lfsr[5]);
            wr_data  = (widx < 4) ? words[32*widx +: 32] : 32'h0;
            ob_ready = (vi % 3 == 0) ? 1'b1 : (lfsr[0] | lfsr[3]);
            if (poke && cyc == 2) begin
                start = 1'b1; pix_count = '0;   // R10: ignored while busy
            end else begin
                start = 1'b0;
            end
            #(CLK_PERIOD/2 - 1);
            if (ob_valid && ob_ready) got_q.push_back(ob_data);
            if (wr_valid && wr_ready) widx++;
            if (done) seen_done = 1'b1;
            @(negedge clk);
            cyc++;
        end
        start = 1'b0; wr_valid = 1'b0; ob_ready = 1'b0;

        chk("R8", $sformatf("vec %0d done", vi), 32'(seen_done), 32'd1);
        chk("R8", $sformatf("vec %0d words", vi), 32'(widx),
            32'((np * mem_bytes(f) + 3) / 4));
        chk(wide ? "R6" : "R5", $sformatf("vec %0d byte count", vi),
            32'(got_q.size()), 32'(exp_q.size()));
        for (int k = 0; k < exp_q.size(); k++) begin
            chk(tag, $sformatf("vec %0d byte %0d (%s)", vi, k, wide ? "R6" : "R5"),
                (k < got_q.size()) ? 32'(got_q[k]) : 32'hFFFF_FFFF, 32'(exp_q[k]));
        end
    endtask

    initial begin
        // R1: reset state
        #(CLK_PERIOD * 2 + 1);
        chk("R1", "busy in reset", 32'(busy), 0);
        chk("R1", "done in reset", 32'(done), 0);
        chk("R1", "ob_valid in reset", 32'(ob_valid), 0);
        chk("R1", "wr_ready in reset", 32'(wr_ready), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "busy after reset", 32'(busy), 0);
        chk("R1", "done after reset", 32'(done), 0);

        for (int vi = 0; vi < NVEC; vi++) run_vec(vi, 1'b0);

        // R10: start while busy is ignored (zero-count start mid-job)
        run_vec(4, 1'b1);

        // R9: zero-count job goes straight to DONE
        @(negedge clk);
        start = 1'b1; pix_count = '0; in_fmt = 3'd4; out_fmt = 1'b1;
        wr_valid = 1'b1; wr_data = 32'h11223344; ob_ready = 1'b1;
        #(CLK_PERIOD/2 - 1);
        chk("R9", "no word in start cycle", 32'(wr_ready), 0);
        @(negedge clk);
        start = 1'b0;
        #(CLK_PERIOD/2 - 1);
        chk("R9", "done after zero job", 32'(done), 1);
        chk("R9", "no byte after zero job", 32'(ob_valid), 0);
        chk("R9", "no word after zero job", 32'(wr_ready), 0);
        chk("R1", "busy clear in done", 32'(busy), 0);
        @(negedge clk);
        wr_valid = 1'b0;

        // R10: restart from DONE after a zero job
        run_vec(8, 1'b0);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule